// File: doc/BRIEF.md
# CAS Timeslot-16 Signaling Inserter

This block sits in the transmit path of a 32-timeslot, 8-bit-per-slot primary-rate framer. It receives the outgoing serial stream one bit per clock. For channel-associated signaling it replaces timeslot 16 of every frame with the multiframe content. Over a 16-frame multiframe, frame 0 carries the multiframe alignment nibble together with three extra bits and a remote alarm bit. Each of frames 1 to 15 carries the four-bit ABCD signaling words of two voice channels. All thirty channel words are supplied in parallel on one input bus.

A frame-start pulse marks bit 0 of timeslot 0. When a multiframe-sync pulse coincides with it, that frame becomes multiframe frame 0. Without the sync pulse, the frame number advances at every frame boundary. A bit counter runs freely between frame starts. Two mode inputs decide whether timeslot 16 is actually rewritten. The source select can take signaling already present in the serial input instead of the parallel bus. The common-channel mode leaves timeslot 16 untouched. In either of those cases the slot passes through unchanged. The output is registered and follows the input by one clock.

Top module: `cas16_ts16_inserter`

## Requirements
- R1: While rst_n is low, ser_out is 0.
- R2: ser_out equals ser_in delayed by exactly one clock for every bit outside timeslot 16 (bit positions 128 to 135 of the 256-bit frame, bit 0 being the one presented with frm_start).
- R3: When insertion is active in multiframe frame 0, timeslot 16 is sent as 0,0,0,0,xtra_bits[2],alarm_bit,xtra_bits[1],xtra_bits[0], in that order.
- R4: When insertion is active in multiframe frame n (1 to 15), timeslot 16 first sends the ABCD word of channel n and then that of channel n+15. Channel c's word is sig_tbl[4c-1:4c-4], with bit 4c-1 being A, which is sent first.
- R5: A frame start with mf_sync high makes that frame multiframe frame 0. A frame start without mf_sync advances the frame number by one, and the frame after frame 15 is frame 0. The first frame start after reset without mf_sync also yields frame 0.
- R6: With src_sel at 0, timeslot 16 passes through from ser_in unchanged.
- R7: With ccs_mode at 1, timeslot 16 passes through from ser_in unchanged, whatever src_sel is.
- R8: Until the first frm_start after reset, every bit passes through unchanged.
- R9: Without frm_start, the bit position wraps from 255 to 0 and the frame number advances. A frm_start at any position restarts the frame at bit 0.
- R10: mf_sync has no effect when frm_start is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | High on bit 0 of timeslot 0 |
| mf_sync | input | 1 | Forces multiframe frame 0 when high with frm_start |
| ser_in | input | 1 | Transmit serial data in |
| src_sel | input | 1 | 1: signaling from sig_tbl; 0: keep ser_in timeslot 16 |
| ccs_mode | input | 1 | 1: common-channel mode, timeslot 16 not rewritten |
| sig_tbl | input | 120 | ABCD words of channels 1 to 30, channel c at bits 4c-1:4c-4 |
| xtra_bits | input | 3 | Extra bits for the frame 0 signaling slot |
| alarm_bit | input | 1 | Remote multiframe alarm bit |
| ser_out | output | 1 | Serial data out, one clock later |

## Verification
The hardest situations to reach are the ones in which frame timing does not come from a frame-start pulse on every frame. One is a long free-running stretch that must wrap both the bit position and the frame number. Another is a frame cut short by an early frame start. The bench reaches them by dropping frm_start for 18 consecutive frames after a single sync. It also cuts a frame at bit 200, after timeslot 16 has already been rewritten, and then restarts. A stray mf_sync placed in the middle of a frame must leave the multiframe count alone. Separate multiframes sweep three channel-word patterns and several extra and alarm bit settings.

// File: rtl/cas16_pkg.sv
package cas16_pkg;
  localparam int SLOT_W = 8;
  localparam logic [3:0] MF_ALIGN_NIB = 4'b0000;

  // frame-0 signaling byte: alignment nibble, then X, Y(alarm), X, X
  function automatic logic [7:0] mf_head_byte(input logic [2:0] xb, input logic alm);
    return {MF_ALIGN_NIB, xb[2], alm, xb[1], xb[0]};
  endfunction

  function automatic logic [7:0] pair_byte(input logic [3:0] first_w, input logic [3:0] second_w);
    return {first_w, second_w};
  endfunction
endpackage

// File: rtl/cas16_locator.sv
module cas16_locator #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int MF_LEN    = 16,
  localparam int PW = $clog2(SLOTS*SLOT_BITS),
  localparam int MW = $clog2(MF_LEN),
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(SLOT_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_start,
  input  logic          mf_sync,
  output logic [SW-1:0] slot_idx,
  output logic [BW-1:0] bit_idx,
  output logic [MW-1:0] frame_idx,
  output logic          aligned,
  output logic          frame_edge
);
  localparam logic [PW-1:0] LAST_POS = PW'(SLOTS*SLOT_BITS-1);
  localparam logic [MW-1:0] LAST_MF  = MW'(MF_LEN-1);

  logic [PW-1:0] pos_q, pos_nx;
  logic [MW-1:0] mf_q, mf_nx;
  logic          algn_q;

  always_comb begin
    if (frm_start)             pos_nx = '0;
    else if (pos_q == LAST_POS) pos_nx = '0;
    else                       pos_nx = pos_q + 1'b1;
  end

  assign frame_edge = frm_start | (algn_q & (pos_q == LAST_POS));
  assign aligned    = frm_start | algn_q;

  always_comb begin
    if (frm_start && mf_sync) mf_nx = '0;
    else if (frame_edge)      mf_nx = (mf_q == LAST_MF) ? '0 : mf_q + 1'b1;
    else                      mf_nx = mf_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= LAST_POS;
      mf_q   <= LAST_MF;
      algn_q <= 1'b0;
    end else begin
      if (aligned) pos_q <= pos_nx;
      mf_q   <= mf_nx;
      algn_q <= aligned;
    end
  end

  assign slot_idx  = SW'(pos_nx / PW'(SLOT_BITS));
  assign bit_idx   = BW'(pos_nx % PW'(SLOT_BITS));
  assign frame_idx = mf_nx;

  assert_mf_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && mf_sync) |=> (mf_q == '0));
  assert_mf_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && !mf_sync && algn_q) |=>
      (mf_q == (($past(mf_q) == LAST_MF) ? '0 : $past(mf_q) + 1'b1)));
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> (pos_q == '0));
  assert_stray_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_start && mf_sync && pos_q != LAST_POS) |=> $stable(mf_q));
endmodule

// File: rtl/cas16_builder.sv
module cas16_builder
  import cas16_pkg::*;
#(
  parameter int CHANS  = 30,
  parameter int MF_LEN = 16,
  localparam int MW = $clog2(MF_LEN)
) (
  input  logic [MW-1:0]      frame_idx,
  input  logic [2:0]         bit_idx,
  input  logic [4*CHANS-1:0] sig_tbl,
  input  logic [2:0]         xtra_bits,
  input  logic               alarm_bit,
  output logic [7:0]         ts_byte,
  output logic               gen_bit
);
  localparam int PAIR_OFS = MF_LEN - 1;

  logic [3:0] word_arr [CHANS];

  for (genvar g = 0; g < CHANS; g++) begin : g_word
    assign word_arr[g] = sig_tbl[4*g +: 4];
  end

  always_comb begin
    int fi;
    logic [3:0] w_first, w_second;
    fi = int'(frame_idx);
    w_first  = 4'h0;
    w_second = 4'h0;
    if (fi >= 1 && fi <= CHANS)            w_first  = word_arr[fi-1];
    if (fi >= 1 && fi + PAIR_OFS <= CHANS) w_second = word_arr[fi-1+PAIR_OFS];
    if (fi == 0) ts_byte = mf_head_byte(xtra_bits, alarm_bit);
    else         ts_byte = pair_byte(w_first, w_second);
  end

  assign gen_bit = ts_byte[~bit_idx];
endmodule

// File: rtl/cas16_ts16_inserter.sv
module cas16_ts16_inserter #(
  parameter int SLOTS     = 32,
  parameter int MF_LEN    = 16,
  parameter int CHANS     = 30,
  parameter int SIG_SLOT  = 16,
  localparam int SLOT_BITS = cas16_pkg::SLOT_W,
  localparam int MW = $clog2(MF_LEN),
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(SLOT_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_start,
  input  logic               mf_sync,
  input  logic               ser_in,
  input  logic               src_sel,
  input  logic               ccs_mode,
  input  logic [4*CHANS-1:0] sig_tbl,
  input  logic [2:0]         xtra_bits,
  input  logic               alarm_bit,
  output logic               ser_out
);
  logic [SW-1:0] slot_idx;
  logic [BW-1:0] bit_idx;
  logic [MW-1:0] frame_idx;
  logic          aligned, frame_edge;
  logic [7:0]    ts_byte;
  logic          gen_bit, ins_en;

  cas16_locator #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .MF_LEN(MF_LEN)) loc_i (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .mf_sync(mf_sync),
    .slot_idx(slot_idx), .bit_idx(bit_idx), .frame_idx(frame_idx),
    .aligned(aligned), .frame_edge(frame_edge));

  cas16_builder #(.CHANS(CHANS), .MF_LEN(MF_LEN)) bld_i (
    .frame_idx(frame_idx), .bit_idx(bit_idx), .sig_tbl(sig_tbl),
    .xtra_bits(xtra_bits), .alarm_bit(alarm_bit),
    .ts_byte(ts_byte), .gen_bit(gen_bit));

  assign ins_en = aligned & ~ccs_mode & src_sel & (slot_idx == SW'(SIG_SLOT));

  always_ff @(posedge clk) begin
    if (!rst_n) ser_out <= 1'b0;
    else        ser_out <= ins_en ? gen_bit : ser_in;
  end

  assert_outside_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx != SW'(SIG_SLOT)) |=> (ser_out == $past(ser_in)));
  assert_mf_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && frame_idx == '0 && bit_idx < BW'(4)) |=> (ser_out == 1'b0));
  assert_src_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !src_sel |=> (ser_out == $past(ser_in)));
  assert_ccs_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ccs_mode |=> (ser_out == $past(ser_in)));
  assert_unaligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |=> (ser_out == $past(ser_in)));
  assert_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_edge |-> (slot_idx == '0 && bit_idx == '0));
endmodule

// File: tb/cas16_ts16_inserter_tb_top.sv
module cas16_ts16_inserter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_start = 1'b0, mf_sync = 1'b0, ser_in = 1'b0;
  logic src_sel = 1'b1, ccs_mode = 1'b0;
  logic [119:0] sig_tbl = '0;
  logic [2:0] xtra_bits = 3'b000;
  logic alarm_bit = 1'b0;
  logic ser_out;

  int n_vec = 0, n_bad = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit b_aligned = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cas16_ts16_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .mf_sync(mf_sync),
    .ser_in(ser_in), .src_sel(src_sel), .ccs_mode(ccs_mode), .sig_tbl(sig_tbl),
    .xtra_bits(xtra_bits), .alarm_bit(alarm_bit), .ser_out(ser_out));

  function automatic logic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // channel c (1..30) word bit k (3=A .. 0=D)
  function automatic logic word_bit(int c, int k);
    return sig_tbl[(c-1)*4 + k];
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input int fno, input int p);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s frame %0d bit %0d: got %b expected %b", req, fno, p, act, exp);
    end
  endtask

  // plays one frame; fno is the multiframe frame number the bench expects
  task automatic run_frame(input bit fs, input bit ms, input int fno,
                           input string tag, input int stop_at = 256, input int stray_at = -1);
    for (int p = 0; p < stop_at; p++) begin
      logic d, e;
      string rq;
      int slot, b;
      d = next_rand();
      frm_start = fs && (p == 0);
      mf_sync   = (ms && p == 0) || (p == stray_at);
      ser_in    = d;
      @(posedge clk);
      @(negedge clk);
      slot = p / 8;
      b    = p % 8;
      if (slot != 16) begin
        e = d; rq = b_aligned ? "R2" : tag;
      end else if (!b_aligned || ccs_mode || !src_sel) begin
        e = d; rq = tag;
      end else if (fno == 0) begin
        rq = "R3";
        if (b < 4)       e = 1'b0;
        else if (b == 4) e = xtra_bits[2];
        else if (b == 5) e = alarm_bit;
        else if (b == 6) e = xtra_bits[1];
        else             e = xtra_bits[0];
      end else begin
        rq = "R4";
        e = word_bit((b < 4) ? fno : fno + 15, 3 - (b % 4));
      end
      if (tag == "R5" || tag == "R9" || tag == "R10") rq = {rq, "/", tag};
      check(ser_out, e, rq, fno, p);
    end
    frm_start = 1'b0;
    mf_sync   = 1'b0;
  endtask

  task automatic load_pattern(input int k);
    for (int c = 1; c <= 30; c++) begin
      case (k)
        0: sig_tbl[(c-1)*4 +: 4] = 4'((c * 7 + 3) % 16);
        1: sig_tbl[(c-1)*4 +: 4] = (c % 2 == 1) ? 4'hA : 4'h5;
        default: sig_tbl[(c-1)*4 +: 4] = 4'(15 - (c % 16));
      endcase
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds output low even with data present
    ser_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ser_out, 1'b0, "R1", 0, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: no frame start yet, timeslot 16 untouched
    load_pattern(0);
    xtra_bits = 3'b101;
    run_frame(0, 0, 0, "R8", 300);
    run_frame(0, 1, 0, "R8", 40);

    // R3/R4/R5: three patterns, synced multiframe then a wrapped one
    b_aligned = 1;
    for (int k = 0; k < 3; k++) begin
      load_pattern(k);
      xtra_bits = 3'(k * 3 + 1);
      alarm_bit = k[0];
      for (int f = 0; f < 16; f++) run_frame(1, f == 0, f, "R5");
      xtra_bits = ~xtra_bits;
      alarm_bit = ~alarm_bit;
      for (int f = 0; f < 16; f++) run_frame(1, 0, f, "R5");
    end

    // R5: resync in the middle of a multiframe
    for (int f = 0; f < 6; f++) run_frame(1, 0, f, "R5");
    for (int f = 0; f < 4; f++) run_frame(1, f == 0, f, "R5");

    // R10: stray sync mid-frame ignored
    run_frame(1, 0, 4, "R10", 256, 100);
    run_frame(1, 0, 5, "R10", 256, 3);
    run_frame(1, 0, 6, "R10");

    // R9: one frame start then free-running for 18 frames
    run_frame(1, 1, 0, "R9");
    for (int f = 1; f <= 18; f++) run_frame(0, 0, f % 16, "R9");
    // R9: frame cut short after timeslot 16, restart at bit 0
    run_frame(1, 0, 3, "R9", 200);
    run_frame(1, 0, 4, "R9");

    // R6: source from serial input
    src_sel = 1'b0;
    for (int f = 0; f < 16; f++) run_frame(1, f == 0, f, "R6");
    // R7: common-channel mode with both source settings
    ccs_mode = 1'b1;
    for (int f = 0; f < 4; f++) run_frame(1, f == 0, f, "R7");
    src_sel = 1'b1;
    for (int f = 0; f < 16; f++) run_frame(1, f == 0, f, "R7");
    ccs_mode = 1'b0;
    for (int f = 0; f < 2; f++) run_frame(1, f == 0, f, "R4");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule